// File: doc/BRIEF.md
# Passive LCD Panel Timing Generator

This block derives the strobes a passive-matrix LCD panel needs from one fast reference clock. A 32-bit configuration word sets the geometry and rates, and an enable input starts and stops the block. While enabled, the block produces a pixel shift clock and groups the pixels into lines. It closes each line with a latch pulse, marks the first line of every frame, and toggles an AC-bias output every few lines. It also emits a one-cycle request each time one 128-bit word of pixel data has been consumed, so that an external fetch engine can keep a pixel FIFO filled.

The configuration word is copied into the block on the rising edge of enable and stays fixed until enable drops. Software therefore changes the word only while the block is idle. Line length is given in units of 16 pixels and frame length in units of 128 bits, each minus one. The pixel depth comes from two grayscale bits and turns the frame length in bits into pixels. The pixel clock low phase that follows each line pulse is twice its normal length.

Top module: `lcd_timing_gen`

## Requirements
- R1: The configuration word is decoded as: bit 31 depth select, bit 30 grayscale on, bits 29:25 AC divider A, bits 24:19 pixel divider P, bits 18:13 line units L, bits 12:0 buffer units B. It is captured on the cycle enable is first seen high, and later changes of `cfg_word` while enabled have no effect on any output.
- R2: With P ≥ 1, `pix_clk` rises once every P+1 reference cycles inside a line. Each high phase lasts floor((P+1)/2) cycles and each normal low phase lasts the rest of the period.
- R3: If P = 0, L = 0 or B < 3 at capture, all five outputs stay low for the whole enabled period.
- R4: A line holds (L+1)×16 pixels. `line_pulse` rises on the same edge that ends the high phase of the line's last pixel, stays high for exactly P+1 cycles, and `pix_clk` is low throughout.
- R5: The `pix_clk` low phase that begins with a `line_pulse` rise lasts twice the normal low phase, so the gap between those two pixel rises is P+1 plus one normal low phase.
- R6: A frame holds (B+1)×128/bpp pixels, where bpp is 1 when bit 30 is 0, 2 when bit 30 is 1 and bit 31 is 0, and 4 when both are 1. The last pixel of a frame also ends its line, so the final line may be short.
- R7: `frame_mark` is high from the first cycle after capture. It falls with the `line_pulse` rise that ends the first line of a frame and rises with the `line_pulse` rise that ends the last line of a frame, so it covers exactly one line of pixels.
- R8: `ac_bias` is low after capture and changes only on a `line_pulse` rise, once every A+1 lines counted from capture.
- R9: `fetch_req` is a one-cycle pulse in the first high cycle of `pix_clk` for every 128/bpp-th pixel of a frame, giving B+1 pulses per frame.
- R10: After reset, and from the cycle after enable is seen low, all outputs are low and all counters restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Run control; rising edge captures the configuration |
| cfg_word | input | 32 | Packed configuration word |
| pix_clk | output | 1 | Pixel shift clock |
| line_pulse | output | 1 | Line latch pulse after each line |
| frame_mark | output | 1 | High during the first line of each frame |
| ac_bias | output | 1 | Panel AC-bias toggle |
| fetch_req | output | 1 | One-cycle request per 128 bits of pixels consumed |

## Verification
The embedded assertions check the local, cycle-level rules on every clock. These are: the line pulse sits inside a low phase of the pixel clock and starts as that clock falls, a fetch request lasts one cycle and lines up with a pixel clock rise, the frame marker and AC bias move only on a line event, a frame end always ends a line, and the outputs are quiet when idle or misconfigured. Counted quantities span many lines and frames, so only the bench scenarios can show them. These are the pixel period and stretched gap, pixels per line including a short last line, pixels, lines and fetches per frame, the lines between AC toggles, and that rewriting the word mid-run changes nothing.

// File: rtl/lcd_tg_pkg.sv
package lcd_tg_pkg;

    localparam int PRE_W   = 6;
    localparam int LINE_W  = 6;
    localparam int BUF_W   = 13;
    localparam int AC_W    = 5;
    localparam int QW_SH   = 7;
    localparam int LINE_SH = 4;
    localparam int MIN_BUF = 3;

    localparam int CFG_W = 2 + AC_W + PRE_W + LINE_W + BUF_W;
    localparam int DIV_W = PRE_W + 2;
    localparam int LPX_W = LINE_W + LINE_SH;
    localparam int FRM_W = BUF_W + QW_SH;
    localparam int QPX_W = QW_SH;

    typedef struct packed {
        logic              deep_px;
        logic              gray_on;
        logic [AC_W-1:0]   ac_div;
        logic [PRE_W-1:0]  pix_div;
        logic [LINE_W-1:0] line_units;
        logic [BUF_W-1:0]  buf_units;
    } lcd_cfg_t;

    typedef enum logic [1:0] {
        DEPTH_1 = 2'd0,
        DEPTH_2 = 2'd1,
        DEPTH_4 = 2'd2
    } depth_sh_e;

    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } pix_phase_e;

    function automatic depth_sh_e depth_of(lcd_cfg_t c);
        if (!c.gray_on)      return DEPTH_1;
        else if (!c.deep_px) return DEPTH_2;
        else                 return DEPTH_4;
    endfunction

    function automatic logic cfg_ok(lcd_cfg_t c);
        return (c.pix_div != '0) && (c.line_units != '0) &&
               (c.buf_units >= BUF_W'(MIN_BUF));
    endfunction

    function automatic logic [LPX_W-1:0] line_last_of(lcd_cfg_t c);
        logic [LPX_W:0] n;
        n = ((LPX_W+1)'(c.line_units) + (LPX_W+1)'(1)) << LINE_SH;
        return LPX_W'(n - (LPX_W+1)'(1));
    endfunction

    function automatic logic [FRM_W-1:0] frame_last_of(lcd_cfg_t c);
        logic [FRM_W:0] n;
        n = ((FRM_W+1)'(c.buf_units) + (FRM_W+1)'(1)) << QW_SH;
        n = n >> int'(depth_of(c));
        return FRM_W'(n - (FRM_W+1)'(1));
    endfunction

    function automatic logic [QPX_W-1:0] quad_last_of(lcd_cfg_t c);
        logic [QPX_W:0] n;
        n = (QPX_W+1)'(1) << QW_SH;
        n = n >> int'(depth_of(c));
        return QPX_W'(n - (QPX_W+1)'(1));
    endfunction

endpackage

// File: rtl/lcd_pix_div.sv
module lcd_pix_div
    import lcd_tg_pkg::*;
#(
    parameter int PW = PRE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic [PW-1:0] pre,
    input  logic          line_end,
    output logic          pix_clk,
    output logic          line_pulse,
    output logic          pix_evt,
    output logic          line_evt
);
    localparam int DW = PW + 2;

    pix_phase_e    ph_q;
    logic [DW-1:0] cnt_q;
    logic          stretch_q;
    logic          cl1_q;
    logic [DW-1:0] cl1_cnt_q;

    logic [DW-1:0] per, hi_len, lo_len, lo_cur;
    logic          lo_done, hi_done;

    always_comb begin
        per     = DW'(pre) + DW'(1);
        hi_len  = per >> 1;
        lo_len  = per - hi_len;
        lo_cur  = stretch_q ? (lo_len << 1) : lo_len;
        lo_done = (ph_q == PH_LOW)  && (cnt_q == lo_cur - DW'(1));
        hi_done = (ph_q == PH_HIGH) && (cnt_q == hi_len - DW'(1));
    end

    assign pix_evt    = !clr && lo_done;
    assign line_evt   = !clr && hi_done && line_end;
    assign pix_clk    = (ph_q == PH_HIGH);
    assign line_pulse = cl1_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            ph_q      <= PH_LOW;
            cnt_q     <= '0;
            stretch_q <= 1'b0;
        end else if (ph_q == PH_LOW) begin
            if (lo_done) begin
                ph_q  <= PH_HIGH;
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + DW'(1);
            end
        end else begin
            if (hi_done) begin
                ph_q      <= PH_LOW;
                cnt_q     <= '0;
                stretch_q <= line_end;
            end else begin
                cnt_q <= cnt_q + DW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cl1_q     <= 1'b0;
            cl1_cnt_q <= '0;
        end else if (line_evt) begin
            cl1_q     <= 1'b1;
            cl1_cnt_q <= '0;
        end else if (cl1_q) begin
            if (cl1_cnt_q == per - DW'(1)) cl1_q <= 1'b0;
            else                           cl1_cnt_q <= cl1_cnt_q + DW'(1);
        end
    end

    AST_CL1_IN_LOW: assert property (@(posedge clk) disable iff (rst)
        line_pulse |-> !pix_clk);                                   // R4
    AST_CL1_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        $rose(line_pulse) |-> $fell(pix_clk));                      // R4

endmodule

// File: rtl/lcd_raster_cnt.sv
module lcd_raster_cnt
    import lcd_tg_pkg::*;
#(
    parameter int LW = LPX_W,
    parameter int FW = FRM_W,
    parameter int QW = QPX_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          pix_evt,
    input  logic [LW-1:0] line_last,
    input  logic [FW-1:0] frame_last,
    input  logic [QW-1:0] quad_last,
    output logic          line_end,
    output logic          frame_end,
    output logic          fetch_req
);
    logic [LW-1:0] px_q;
    logic [FW-1:0] fp_q;
    logic [QW-1:0] qc_q;
    logic          line_end_q, frame_end_q, fetch_q;

    logic f_last, l_last, q_last;

    always_comb begin
        f_last = (fp_q == frame_last);
        l_last = (px_q == line_last) || f_last;
        q_last = (qc_q == quad_last) || f_last;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            px_q        <= '0;
            fp_q        <= '0;
            qc_q        <= '0;
            line_end_q  <= 1'b0;
            frame_end_q <= 1'b0;
            fetch_q     <= 1'b0;
        end else if (pix_evt) begin
            px_q        <= l_last ? '0 : px_q + LW'(1);
            fp_q        <= f_last ? '0 : fp_q + FW'(1);
            qc_q        <= q_last ? '0 : qc_q + QW'(1);
            line_end_q  <= l_last;
            frame_end_q <= f_last;
            fetch_q     <= q_last;
        end else begin
            fetch_q <= 1'b0;
        end
    end

    assign line_end  = line_end_q;
    assign frame_end = frame_end_q;
    assign fetch_req = fetch_q;

    AST_FETCH_SINGLE: assert property (@(posedge clk) disable iff (rst)
        fetch_req |=> !fetch_req);                                  // R9
    AST_FRAME_ENDS_LINE: assert property (@(posedge clk) disable iff (rst)
        frame_end |-> line_end);                                    // R6

endmodule

// File: rtl/lcd_frame_ctl.sv
module lcd_frame_ctl
    import lcd_tg_pkg::*;
#(
    parameter int AW = AC_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          load,
    input  logic          legal,
    input  logic          line_evt,
    input  logic          frame_end,
    input  logic [AW-1:0] ac_div,
    output logic          frame_mark,
    output logic          ac_bias
);
    logic          flm_q, ac_q;
    logic [AW-1:0] acc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            flm_q <= 1'b0;
            ac_q  <= 1'b0;
            acc_q <= '0;
        end else if (load) begin
            flm_q <= legal;
            ac_q  <= 1'b0;
            acc_q <= '0;
        end else if (clr) begin
            flm_q <= 1'b0;
            ac_q  <= 1'b0;
            acc_q <= '0;
        end else if (line_evt) begin
            flm_q <= frame_end;
            if (acc_q == ac_div) begin
                acc_q <= '0;
                ac_q  <= ~ac_q;
            end else begin
                acc_q <= acc_q + AW'(1);
            end
        end
    end

    assign frame_mark = flm_q;
    assign ac_bias    = ac_q;

    AST_AC_ON_LINE: assert property (@(posedge clk) disable iff (rst)
        (!line_evt && !load && !clr) |=> $stable(ac_bias));         // R8
    AST_FLM_ON_LINE: assert property (@(posedge clk) disable iff (rst)
        (!line_evt && !load && !clr) |=> $stable(frame_mark));      // R7

endmodule

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen
    import lcd_tg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic [CFG_W-1:0] cfg_word,
    output logic             pix_clk,
    output logic             line_pulse,
    output logic             frame_mark,
    output logic             ac_bias,
    output logic             fetch_req
);
    lcd_cfg_t cfg_q;
    logic     run_q, ok_q;
    logic     load, clr;

    logic [LPX_W-1:0] line_last;
    logic [FRM_W-1:0] frame_last;
    logic [QPX_W-1:0] quad_last;

    logic pix_evt, line_evt, line_end, frame_end;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= 1'b0;
            ok_q  <= 1'b0;
            cfg_q <= '0;
        end else if (!enable) begin
            run_q <= 1'b0;
        end else if (!run_q) begin
            run_q <= 1'b1;
            cfg_q <= lcd_cfg_t'(cfg_word);
            ok_q  <= cfg_ok(lcd_cfg_t'(cfg_word));
        end
    end

    assign load = enable && !run_q;
    assign clr  = !(enable && run_q && ok_q);

    always_comb begin
        line_last  = line_last_of(cfg_q);
        frame_last = frame_last_of(cfg_q);
        quad_last  = quad_last_of(cfg_q);
    end

    lcd_pix_div #(.PW(PRE_W)) u_div (
        .clk        (clk),
        .rst        (rst),
        .clr        (clr),
        .pre        (cfg_q.pix_div),
        .line_end   (line_end),
        .pix_clk    (pix_clk),
        .line_pulse (line_pulse),
        .pix_evt    (pix_evt),
        .line_evt   (line_evt)
    );

    lcd_raster_cnt #(.LW(LPX_W), .FW(FRM_W), .QW(QPX_W)) u_raster (
        .clk        (clk),
        .rst        (rst),
        .clr        (clr),
        .pix_evt    (pix_evt),
        .line_last  (line_last),
        .frame_last (frame_last),
        .quad_last  (quad_last),
        .line_end   (line_end),
        .frame_end  (frame_end),
        .fetch_req  (fetch_req)
    );

    lcd_frame_ctl #(.AW(AC_W)) u_frame (
        .clk        (clk),
        .rst        (rst),
        .clr        (clr),
        .load       (load),
        .legal      (cfg_ok(lcd_cfg_t'(cfg_word))),
        .line_evt   (line_evt),
        .frame_end  (frame_end),
        .ac_div     (cfg_q.ac_div),
        .frame_mark (frame_mark),
        .ac_bias    (ac_bias)
    );

    AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (rst)
        !run_q |-> !(pix_clk || line_pulse || frame_mark || ac_bias || fetch_req));   // R10
    AST_QUIET_ILLEGAL: assert property (@(posedge clk) disable iff (rst)
        (run_q && !ok_q) |-> !(pix_clk || line_pulse || frame_mark || ac_bias || fetch_req)); // R3
    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (run_q && $past(run_q)) |-> $stable(cfg_q));                // R1
    AST_FETCH_ON_RISE: assert property (@(posedge clk) disable iff (rst)
        fetch_req |-> (pix_clk && !$past(pix_clk)));                // R9

endmodule

// File: tb/tb_lcd_timing_gen.sv
`timescale 1ns/1ps
module tb_lcd_timing_gen;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        enable = 1'b0;
    logic [31:0] cfg_word = '0;
    logic        pix_clk, line_pulse, frame_mark, ac_bias, fetch_req;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    lcd_timing_gen dut (
        .clk        (clk),
        .rst        (rst),
        .enable     (enable),
        .cfg_word   (cfg_word),
        .pix_clk    (pix_clk),
        .line_pulse (line_pulse),
        .frame_mark (frame_mark),
        .ac_bias    (ac_bias),
        .fetch_req  (fetch_req)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input bit dp, input bit gr, input int ac,
                                       input int pp, input int ll, input int bs);
        logic [31:0] w;
        w = {dp, gr, ac[4:0], pp[5:0], ll[5:0], bs[12:0]};
        return w;
    endfunction

    function automatic bit any_out();
        return pix_clk || line_pulse || frame_mark || ac_bias || fetch_req;
    endfunction

    task automatic test_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!any_out(), "R10 reset", int'(any_out()), 0);
    endtask

    // Runs one legal configuration and measures every counted behaviour.
    task automatic run_cfg(input logic [31:0] w, input logic [31:0] alt,
                           input bit swap, input int ncyc, input string tag);
        int p   = int'(w[24:19]);
        int ll  = int'(w[18:13]);
        int bs  = int'(w[12:0]);
        int ac  = int'(w[29:25]);
        int bpp = w[30] ? (w[31] ? 4 : 2) : 1;
        int per = p + 1;
        int hl  = per / 2;
        int lo  = per - hl;
        int lp  = (ll + 1) * 16;
        int fpx = (bs + 1) * 128 / bpp;
        int qp  = 128 / bpp;
        int nl  = (fpx + lp - 1) / lp;
        logic pp_ = 0, cp = 0, fp_ = 0, ap = 0, qpv = 0;
        int gap = 0, hcnt = 0, ccnt = 0, nrise = 0, ncl1 = 0, since = 0;
        int pil = 0, frpx = 0, frl = 0, frf = 0, pflm = 0, acl = 0, qcnt = 0;
        int nfr = 0, seen = 0, ntog = 0;
        int rec_fpx = -1, rec_fl = -1, rec_ff = -1, rec_flm = -1;
        int gap_bad = 0, st_bad = 0, hi_bad = 0, cw_bad = 0, ov_bad = 0;
        int fe_bad = 0, qg_bad = 0, ac_bad = 0, fl_bad = 0, ln_bad = 0;
        int line_px[64];

        @(negedge clk);
        cfg_word = w;
        enable   = 1'b1;
        for (int i = 0; i < ncyc; i++) begin
            bit pr, pf, cr, cf, frs, ffl;
            @(negedge clk);
            if (i == 0) begin
                chk(frame_mark && !pix_clk && !line_pulse && !ac_bias,
                    {tag, " R7 start"}, int'(frame_mark), 1);
                if (swap) cfg_word = alt;
            end
            pr  = pix_clk && !pp_;
            pf  = !pix_clk && pp_;
            cr  = line_pulse && !cp;
            cf  = !line_pulse && cp;
            frs = frame_mark && !fp_;
            ffl = !frame_mark && fp_;
            gap++;
            if (pr) begin
                if (nrise > 0) begin
                    if (since != 0 && gap != per + lo) st_bad++;
                    if (since == 0 && gap != per)      gap_bad++;
                end
                gap = 0; since = 0; nrise++;
                pil++; frpx++; qcnt++;
                if (frame_mark) pflm++;
                hcnt = 1;
            end else if (pix_clk) begin
                hcnt++;
            end
            if (pf && hcnt != hl) hi_bad++;
            if (cr) begin
                if (ncl1 < 64) line_px[ncl1] = pil;
                pil = 0; ncl1++; frl++; acl++; since = 1; ccnt = 1;
            end else if (line_pulse) begin
                ccnt++;
            end
            if (cf && ccnt != per) cw_bad++;
            if (line_pulse && pix_clk) ov_bad++;
            if (fetch_req) begin
                if (!pr || qpv) fe_bad++;
                if (qcnt != qp) qg_bad++;
                qcnt = 0; frf++;
            end
            if (ac_bias != ap) begin
                if (!cr || acl != ac + 1) ac_bad++;
                acl = 0; ntog++;
            end
            if (frs) begin
                if (seen != 0) begin
                    rec_fpx = frpx; rec_fl = frl; rec_ff = frf; nfr++;
                    if (!cr) fl_bad++;
                end
                seen = 1; frpx = 0; frl = 0; frf = 0;
            end
            if (ffl) begin
                rec_flm = pflm; pflm = 0;
                if (!cr) fl_bad++;
            end
            pp_ = pix_clk; cp = line_pulse; fp_ = frame_mark;
            ap = ac_bias; qpv = fetch_req;
        end

        for (int j = 0; j < ncl1 && j < 64; j++) begin
            int k = j % nl;
            int e = (k == nl - 1) ? fpx - (nl - 1) * lp : lp;
            if (line_px[j] != e) ln_bad++;
        end

        chk(nrise > 0 && gap_bad == 0, {tag, " R2 period"}, gap_bad, 0);
        chk(hi_bad == 0, {tag, " R2 high phase"}, hi_bad, 0);
        chk(st_bad == 0, {tag, " R5 stretched gap"}, st_bad, 0);
        chk(cw_bad == 0 && ov_bad == 0, {tag, " R4 line pulse"}, cw_bad + ov_bad, 0);
        chk(ln_bad == 0 && ncl1 > 0, {tag, " R4 pixels per line"}, ln_bad, 0);
        chk(rec_fpx == fpx, {tag, " R6 pixels per frame"}, rec_fpx, fpx);
        chk(rec_fl == nl, {tag, " R6 lines per frame"}, rec_fl, nl);
        chk(rec_flm == lp && fl_bad == 0 && nfr >= 2, {tag, " R7 frame mark"}, rec_flm, lp);
        chk(ac_bad == 0 && ntog > 0, {tag, " R8 ac bias"}, ac_bad, 0);
        chk(fe_bad == 0 && qg_bad == 0, {tag, " R9 fetch timing"}, fe_bad + qg_bad, 0);
        chk(rec_ff == bs + 1, {tag, " R9 fetch per frame"}, rec_ff, bs + 1);
        if (swap) chk(rec_fpx == fpx && gap_bad == 0, {tag, " R1 held config"}, rec_fpx, fpx);

        enable = 1'b0;
        @(negedge clk);
        chk(!any_out(), {tag, " R10 disable"}, int'(any_out()), 0);
        repeat (4) @(negedge clk);
    endtask

    task automatic test_quiet(input logic [31:0] w, input string tag);
        int bad = 0;
        @(negedge clk);
        cfg_word = w;
        enable   = 1'b1;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (any_out()) bad++;
        end
        chk(bad == 0, {tag, " R3 illegal stays quiet"}, bad, 0);
        enable = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        test_reset();
        // 1 bpp, P=3, 32-pixel lines, 512-pixel frame, AC every 3 lines
        run_cfg(mk(0, 0, 2, 3, 1, 3), '0, 1'b0, 6400, "A");
        // 4 bpp, P=4, 128-pixel frame, AC every line
        run_cfg(mk(1, 1, 0, 4, 1, 3), '0, 1'b0, 2100, "B");
        // 2 bpp, P=1, 48-pixel lines, 320-pixel frame with short last line
        run_cfg(mk(0, 1, 1, 1, 2, 4), '0, 1'b0, 2100, "C");
        // mid-run rewrite of the word must change nothing (R1)
        run_cfg(mk(0, 0, 2, 3, 1, 3), mk(1, 1, 0, 4, 1, 3), 1'b1, 4400, "HOLD");
        test_quiet(mk(0, 0, 2, 0, 1, 3), "P0");
        test_quiet(mk(0, 0, 2, 3, 0, 3), "L0");
        test_quiet(mk(0, 0, 2, 3, 1, 2), "B2");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(100000 * 8);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule